// File: doc/BRIEF.md
# Serial-Addressed DAC Code Register Bank

This block takes 16-bit command words from a three-wire serial link (data, shift clock, active-low select) and keeps a bank of twelve 8-bit converter codes together with a drive flag for each channel. A host lowers the select line and clocks in one word, most significant bit first. When the select line rises after exactly sixteen clock edges, the word is decoded. The low four bits give the address. The upper twelve bits carry the payload.

Channels 1 to 4 always drive. Channels 5 to 12 can be released, so that their pins can be used as digital I/O. A payload flag releases one such channel, and a broadcast word releases all eight of them. Addresses 13 to 15 are not stored. They are forwarded as a one-cycle command to a companion port block. The shift register is visible on a serial-out pin, so a second device can be chained behind this one.

The serial lines are resynchronised to the fast system clock, and their edges are found by comparing samples. A small state machine controls the frame. Its states are ST_IDLE (select high), ST_SHIFT (select low, edges counted) and ST_APPLY (one cycle in which the word is acted on). It has four transitions: ST_IDLE to ST_SHIFT on a select fall, ST_SHIFT to ST_APPLY on a select rise after exactly 16 edges, ST_SHIFT to ST_IDLE on a select rise after any other count, and ST_APPLY to ST_IDLE unconditionally.

Top module: `dac_code_bank`

## Requirements
- R1: Data bits are captured on rising shift-clock edges while `ser_cs_n` is low, most significant bit first. The 16-bit word is acted on only after `ser_cs_n` returns high, and its effect shows on the outputs within 8 system clocks.
- R2: An address (bits [3:0]) of 1 to 12 loads channel N with bits [15:8]. Bits [7:5] have no effect.
- R3: For channels 5 to 12, the drive flag becomes the inverse of bit 4 of the addressed word. Bit 4 = 1 releases the channel and bit 4 = 0 drives it. The code is loaded in both cases.
- R4: Channels 1 to 4 have drive flag 1 at all times, whatever the value of bit 4.
- R5: A word whose low byte is 8'hD0 clears the drive flags of channels 5 to 12. It changes no code, changes no flag of channels 1 to 4, and raises no port command.
- R6: After reset, all codes are 0, `dac_drive` is 12'h00F and `so_oe` is 0.
- R7: Addresses 13, 14 and 15 raise `iox_valid` for exactly one cycle. `iox_op` is 0 (write), 1 (capture) or 2 (direction) respectively, `iox_data` carries bits [15:4], and codes and drive flags stay unchanged.
- R8: `so_data` shows the shift register's most significant bit, so the previous word leaves MSB first while the next one enters. `so_oe` is 1 only while the synchronised select is low.
- R9: A frame whose select rise follows a count of edges other than 16 changes no code, no flag and raises no port command.
- R10: Address 0 with any low byte other than 8'hD0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the shift clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_din | input | 1 | Serial data in |
| ser_sclk | input | 1 | Serial shift clock |
| ser_cs_n | input | 1 | Active-low frame select |
| dac_code | output | NCH*8 | Packed codes, channel 1 in bits [7:0] |
| dac_drive | output | NCH | Per-channel drive flag, 1 = driven, 0 = high impedance |
| so_data | output | 1 | Cascade serial out (shift register MSB) |
| so_oe | output | 1 | Enable for the cascade output |
| iox_valid | output | 1 | One-cycle port command strobe |
| iox_op | output | 2 | Port command: 0 write, 1 capture, 2 direction, 3 none |
| iox_data | output | 12 | Port command payload, word bits [15:4] |

## Verification
The bench builds the block with its default parameters: twelve channels, four of them always driven, and two synchroniser stages. With these values every address and both tri-state paths are reachable, including the gap between the fixed and the releasable channels and the three port commands directly above the last channel. The serial clock runs at one eighth of the system rate, so the synchroniser latency and the edge counting are exercised with short (15-edge) and long (17-edge) frames. The cascade output is compared bit by bit against the word that was shifted in before.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;

    localparam int FRAME_W = 16;
    localparam int ADDR_W  = 4;
    localparam int CODE_W  = 8;
    localparam int IOX_W   = FRAME_W - ADDR_W;

    // Low byte that releases every releasable channel at once.
    localparam logic [7:0] BCAST_BYTE = 8'hD0;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_APPLY = 2'd2
    } frm_state_e;

    typedef enum logic [1:0] {
        IOX_WRITE   = 2'd0,
        IOX_CAPTURE = 2'd1,
        IOX_DIR     = 2'd2,
        IOX_NONE    = 2'd3
    } iox_op_e;

endpackage

// File: rtl/dcb_sync.sv
module dcb_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= {STAGES{RST_VAL}};
        end else begin
            pipe <= {pipe[STAGES-2:0], d};
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/dcb_frame_ctrl.sv
module dcb_frame_ctrl
    import dac_bank_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               din_s,
    input  logic               sclk_s,
    input  logic               cs_n_s,
    output logic [FRAME_W-1:0] frame,
    output logic               apply,
    output logic               so_data
);

    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

    frm_state_e         state_q, state_d;
    logic               sclk_q, cs_q;
    logic               sclk_rise, cs_rise, cs_fall;
    logic [FRAME_W-1:0] sr;
    logic [CNT_W-1:0]   cnt;

    assign sclk_rise = sclk_s & ~sclk_q;
    assign cs_rise   = cs_n_s & ~cs_q;
    assign cs_fall   = ~cs_n_s & cs_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cs_fall) state_d = ST_SHIFT;
            ST_SHIFT: if (cs_rise) state_d = (cnt == CNT_FULL) ? ST_APPLY : ST_IDLE;
            ST_APPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Edge history, shift register and edge counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
            sr     <= '0;
            cnt    <= '0;
        end else begin
            sclk_q <= sclk_s;
            cs_q   <= cs_n_s;
            if (state_q == ST_IDLE && cs_fall) begin
                cnt <= '0;
            end else if (state_q == ST_SHIFT && sclk_rise) begin
                sr <= {sr[FRAME_W-2:0], din_s};
                if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        apply   = (state_q == ST_APPLY);
        frame   = sr;
        so_data = sr[FRAME_W-1];
    end

endmodule

// File: rtl/dcb_code_bank.sv
module dcb_code_bank
    import dac_bank_pkg::*;
#(
    parameter int NCH    = 12,
    parameter int NFIXED = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  apply,
    input  logic [FRAME_W-1:0]    frame,
    output logic [NCH*CODE_W-1:0] dac_code,
    output logic [NCH-1:0]        dac_drive,
    output logic                  iox_valid,
    output logic [1:0]            iox_op,
    output logic [IOX_W-1:0]      iox_data
);

    localparam int IOX_BASE = NCH + 1;
    localparam int IOX_LAST = NCH + 3;

    logic [ADDR_W-1:0] addr;
    logic              bcast;
    int                addr_i;

    assign addr   = frame[ADDR_W-1:0];
    assign addr_i = int'(addr);
    assign bcast  = apply && (addr == '0) && (frame[7:0] == BCAST_BYTE);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic sel;
        assign sel = apply && (addr_i == ch + 1);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dac_code[ch*CODE_W +: CODE_W] <= '0;
            end else if (sel) begin
                dac_code[ch*CODE_W +: CODE_W] <= frame[FRAME_W-1 -: CODE_W];
            end
        end

        if (ch < NFIXED) begin : g_fixed
            assign dac_drive[ch] = 1'b1;
        end else begin : g_rel
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    dac_drive[ch] <= 1'b0;
                end else if (sel) begin
                    dac_drive[ch] <= ~frame[ADDR_W];
                end else if (bcast) begin
                    dac_drive[ch] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        iox_valid = apply && (addr_i >= IOX_BASE) && (addr_i <= IOX_LAST);
        iox_op    = iox_valid ? 2'(addr_i - IOX_BASE) : IOX_NONE;
        iox_data  = frame[FRAME_W-1:ADDR_W];
    end

endmodule

// File: rtl/dac_code_bank.sv
module dac_code_bank
    import dac_bank_pkg::*;
#(
    parameter int NCH         = 12,
    parameter int NFIXED      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ser_din,
    input  logic                  ser_sclk,
    input  logic                  ser_cs_n,
    output logic [NCH*CODE_W-1:0] dac_code,
    output logic [NCH-1:0]        dac_drive,
    output logic                  so_data,
    output logic                  so_oe,
    output logic                  iox_valid,
    output logic [1:0]            iox_op,
    output logic [IOX_W-1:0]      iox_data
);

    logic               din_s, sclk_s, cs_n_s;
    logic               frm_apply;
    logic [FRAME_W-1:0] frm_word;

    dcb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_din (
        .clk(clk), .rst_n(rst_n), .d(ser_din), .q(din_s)
    );
    dcb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
        .clk(clk), .rst_n(rst_n), .d(ser_sclk), .q(sclk_s)
    );
    dcb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .d(ser_cs_n), .q(cs_n_s)
    );

    dcb_frame_ctrl u_frame (
        .clk(clk), .rst_n(rst_n),
        .din_s(din_s), .sclk_s(sclk_s), .cs_n_s(cs_n_s),
        .frame(frm_word), .apply(frm_apply), .so_data(so_data)
    );

    dcb_code_bank #(.NCH(NCH), .NFIXED(NFIXED)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .apply(frm_apply), .frame(frm_word),
        .dac_code(dac_code), .dac_drive(dac_drive),
        .iox_valid(iox_valid), .iox_op(iox_op), .iox_data(iox_data)
    );

    assign so_oe = ~cs_n_s;

endmodule

// File: rtl/dac_code_bank_chk.sv
module dac_code_bank_chk #(
    parameter int NCH    = 12,
    parameter int CODE_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ser_cs_n,
    input logic                  apply,
    input logic [NCH*CODE_W-1:0] dac_code,
    input logic [NCH-1:0]        dac_drive,
    input logic                  so_oe,
    input logic                  iox_valid
);

    AST_CODE_ONLY_ON_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_code) |-> $past(apply)); // R1

    AST_DRIVE_ONLY_ON_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_drive) |-> $past(apply)); // R3

    AST_IOX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        iox_valid |=> !iox_valid); // R7

    AST_IOX_KEEPS_DAC: assert property (@(posedge clk) disable iff (!rst_n)
        iox_valid |=> ($stable(dac_code) && $stable(dac_drive))); // R7

    AST_SO_OFF_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_cs_n && $past(ser_cs_n) && $past(ser_cs_n, 2) && $past(ser_cs_n, 3)) |-> !so_oe); // R8

endmodule

bind dac_code_bank dac_code_bank_chk #(
    .NCH(NCH),
    .CODE_W(dac_bank_pkg::CODE_W)
) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .ser_cs_n(ser_cs_n),
    .apply(frm_apply),
    .dac_code(dac_code),
    .dac_drive(dac_drive),
    .so_oe(so_oe),
    .iox_valid(iox_valid)
);

// File: tb/tb_dac_code_bank.sv
module tb_dac_code_bank;

    localparam int NCH    = 12;
    localparam int NFIXED = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_din = 1'b0;
    logic ser_sclk = 1'b0;
    logic ser_cs_n = 1'b1;
    logic [NCH*8-1:0] dac_code;
    logic [NCH-1:0]   dac_drive;
    logic so_data, so_oe, iox_valid;
    logic [1:0]  iox_op;
    logic [11:0] iox_data;

    dac_code_bank dut (
        .clk(clk), .rst_n(rst_n),
        .ser_din(ser_din), .ser_sclk(ser_sclk), .ser_cs_n(ser_cs_n),
        .dac_code(dac_code), .dac_drive(dac_drive),
        .so_data(so_data), .so_oe(so_oe),
        .iox_valid(iox_valid), .iox_op(iox_op), .iox_data(iox_data)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Behavioural reference state
    logic [7:0]     m_code [NCH];
    logic [NCH-1:0] m_drive;
    logic [15:0]    m_sr;
    bit             stable = 1'b0;
    int             iox_cnt = 0;
    logic [1:0]     iox_op_seen;
    logic [11:0]    iox_data_seen;

    task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [NCH*8-1:0] exp_codes();
        logic [NCH*8-1:0] v;
        for (int c = 0; c < NCH; c++) v[c*8 +: 8] = m_code[c];
        return v;
    endfunction

    // Every-clock comparison against the reference, plus port strobe capture
    always @(negedge clk) begin
        if (iox_valid) begin
            iox_cnt++;
            iox_op_seen   = iox_op;
            iox_data_seen = iox_data;
        end
        if (rst_n && stable) begin
            chk(dac_code == exp_codes(), "R2 codes", 96'(dac_code), 96'(exp_codes()));
            chk(dac_drive == m_drive, "R3 R4 drive", 96'(dac_drive), 96'(m_drive));
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic void model_apply(input logic [15:0] f);
        int a;
        a = int'(f[3:0]);
        if (a >= 1 && a <= NCH) begin
            m_code[a-1] = f[15:8];
            if (a - 1 >= NFIXED) m_drive[a-1] = ~f[4];
        end else if (a == 0 && f[7:0] == 8'hD0) begin
            m_drive[NCH-1:NFIXED] = '0;
        end
    endfunction

    task automatic send(input logic [31:0] bits, input int n);
        iox_cnt = 0;
        ser_cs_n = 1'b0;
        wait_n(4);
        for (int i = 0; i < n; i++) begin
            ser_din = bits[n-1-i];
            wait_n(4);
            chk(so_oe == 1'b1 && so_data == m_sr[15], "R8 cascade",
                96'({so_oe, so_data}), 96'({1'b1, m_sr[15]}));
            ser_sclk = 1'b1;
            m_sr = {m_sr[14:0], bits[n-1-i]};
            wait_n(4);
            ser_sclk = 1'b0;
        end
        wait_n(2);
        stable = 1'b0;
        ser_cs_n = 1'b1;
        wait_n(8);
        if (n == 16) model_apply(bits[15:0]);
        stable = 1'b1;
        chk(so_oe == 1'b0, "R8 idle oe", 96'(so_oe), 96'(0));
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) m_code[c] = 8'h00;
        m_drive = 12'h00F;
        m_sr    = 16'h0000;
        wait_n(4);
        // R6: reset state
        chk(dac_code == '0, "R6 codes", 96'(dac_code), 96'(0));
        chk(dac_drive == 12'h00F, "R6 drive", 96'(dac_drive), 96'(12'h00F));
        chk(so_oe == 1'b0, "R6 oe", 96'(so_oe), 96'(0));
        rst_n = 1'b1;
        wait_n(3);
        stable = 1'b1;

        // R1 R2 R4: ch1, bits[7:5] set and flag set, still driven
        send({16'h0, 8'hA5, 4'b1111, 4'd1}, 16);
        chk(dac_code[7:0] == 8'hA5, "R1 R2 ch1 code", 96'(dac_code[7:0]), 96'(8'hA5));
        chk(dac_drive[0] == 1'b1, "R4 ch1 driven", 96'(dac_drive[0]), 96'(1));

        // R3: ch5 driven with code
        send({16'h0, 8'h3C, 4'b0000, 4'd5}, 16);
        chk(dac_drive[4] == 1'b1 && dac_code[39:32] == 8'h3C, "R3 ch5 on",
            96'({dac_drive[4], dac_code[39:32]}), 96'({1'b1, 8'h3C}));
        send({16'h0, 8'hFF, 4'b0000, 4'd12}, 16);
        send({16'h0, 8'h11, 4'b0000, 4'd7}, 16);
        // R3: ch7 released
        send({16'h0, 8'h22, 4'b0001, 4'd7}, 16);
        chk(dac_drive[6] == 1'b0, "R3 ch7 released", 96'(dac_drive[6]), 96'(0));
        // R4: ch4 flag set stays driven
        send({16'h0, 8'h44, 4'b0001, 4'd4}, 16);
        chk(dac_drive[3] == 1'b1, "R4 ch4 driven", 96'(dac_drive[3]), 96'(1));

        // R10: address 0, non-broadcast byte
        send({16'h0, 8'hEE, 8'h50}, 16);
        chk(dac_drive == 12'h81F, "R10 ignored", 96'(dac_drive), 96'(12'h81F));

        // R5: broadcast release
        send({16'h0, 8'h77, 8'hD0}, 16);
        chk(dac_drive == 12'h00F && iox_cnt == 0, "R5 broadcast",
            96'({dac_drive, 8'(iox_cnt)}), 96'({12'h00F, 8'd0}));
        chk(dac_code[95:88] == 8'hFF, "R5 codes kept", 96'(dac_code[95:88]), 96'(8'hFF));

        // R7: port commands
        send({16'h0, 12'hABC, 4'd13}, 16);
        chk(iox_cnt == 1 && iox_op_seen == 2'd0 && iox_data_seen == 12'hABC, "R7 write",
            96'({8'(iox_cnt), iox_op_seen, iox_data_seen}), 96'({8'd1, 2'd0, 12'hABC}));
        send({16'h0, 12'h123, 4'd14}, 16);
        chk(iox_cnt == 1 && iox_op_seen == 2'd1 && iox_data_seen == 12'h123, "R7 capture",
            96'({8'(iox_cnt), iox_op_seen, iox_data_seen}), 96'({8'd1, 2'd1, 12'h123}));
        send({16'h0, 12'hF0F, 4'd15}, 16);
        chk(iox_cnt == 1 && iox_op_seen == 2'd2 && iox_data_seen == 12'hF0F, "R7 direction",
            96'({8'(iox_cnt), iox_op_seen, iox_data_seen}), 96'({8'd1, 2'd2, 12'hF0F}));

        // R9: short and long frames discarded
        send({17'h0, 7'h5A, 4'b0000, 4'd2}, 15);
        chk(dac_code[15:8] == 8'h00, "R9 short frame", 96'(dac_code[15:8]), 96'(0));
        send({15'h0, 1'b1, 8'h66, 4'b0000, 4'd3}, 17);
        chk(dac_code[23:16] == 8'h00, "R9 long frame", 96'(dac_code[23:16]), 96'(0));
        send({16'h0, 8'h99, 4'b0000, 4'd14}, 17);
        chk(iox_cnt == 0, "R9 no strobe", 96'(iox_cnt), 96'(0));

        // R1: final ordinary write after the discarded frames
        send({16'h0, 8'h5E, 4'b0000, 4'd9}, 16);
        chk(dac_code[71:64] == 8'h5E && dac_drive[8] == 1'b1, "R1 recovery",
            96'({dac_drive[8], dac_code[71:64]}), 96'({1'b1, 8'h5E}));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule